// File: doc/BRIEF.md
# Replicated Lane Streaming Kernel

This block evaluates y = K + ((a + b) * (c + c)) for every item of a work-group held in an on-chip local memory. K is a scalar input. The operands a, b and c are unsigned fixed-width integers. A parameterised number of identical lanes work in lockstep. Each lane owns one read port per operand array and one write port for the result array, and all of these ports belong to a single multi-ported memory that sits outside the block. The memory answers a read one cycle after the address is presented.

A start pulse sends the shared step counter back to zero and begins a pass. At step s, lane L reads item s*N + L, where N is the lane count. The operands then pass through three registered stages. The first stage forms both sums side by side. The second stage multiplies them. The third stage adds K. Each lane writes its result back to the index it read. Because every lane accepts one item per cycle, a pass over ITEMS items takes ITEMS/N issue cycles plus the pipeline depth. A done flag reports that the whole work-group has been written.

Top module: `lane_array_kernel`

## Requirements
- R1: Every written result equals K + (a + b) * (2 * c), with all values unsigned and nothing wrapped. The result is 2*(W+1)+1 bits wide, which is 19 bits for W = 8.
- R2: At step s, lane L drives read address s*N + L. Four cycles later the same lane writes that item's result to the same address. Lane L occupies bits [L*AW +: AW] of each address bus and bits [L*YW +: YW] of the write data bus.
- R3: In one pass, each index from 0 to ITEMS-1 is written exactly once.
- R4: Let start be sampled high at clock edge E. Then rd_en is high for cycles 0 to ITEMS/N - 1 after E. wr_en is high for cycles 4 to ITEMS/N + 3. done is high from cycle ITEMS/N + 4, which is the cycle after the final write.
- R5: After reset, with no start pulse, rd_en, all wr_en bits and done are low, and no write takes place.
- R6: done stays high until the next start pulse. That pulse clears done on the same edge and begins a new pass from step 0.
- R7: All lanes write in the same cycles. While a pass is streaming, each lane writes one new item every cycle.
- R8: A write happens only four cycles after a read was issued. No read is issued while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a pass |
| k_in | input | W | Scalar K added to every product |
| rd_en | output | 1 | Read strobe shared by all lane ports |
| rd_addr | output | LANES*AW | Per-lane read address |
| a_rd | input | LANES*W | Per-lane a data, one cycle after the address |
| b_rd | input | LANES*W | Per-lane b data, one cycle after the address |
| c_rd | input | LANES*W | Per-lane c data, one cycle after the address |
| wr_en | output | LANES | Per-lane result write strobe |
| wr_addr | output | LANES*AW | Per-lane result address |
| wr_data | output | LANES*YW | Per-lane result value |
| done | output | 1 | Work-group complete |

## Verification
If a lane's step tag or valid chain is corrupted, the error shows at the ports four cycles after the faulty read. It appears as a write to the wrong address, a missing write, or a doubled write, and the per-index write tally exposes it after the pass. If the step counter or the done logic is wrong, the cycle at which rd_en falls or done rises moves away from ITEMS/N + 4. That is visible on the first pass. A wrong operand width or a wrong stage in the arithmetic shows up as a bad stored value at the extreme operand vectors, which are placed so that every lane and the first and last steps see them.

// File: rtl/lk_pkg.sv
package lk_pkg;
   // Width of a counter or index that must hold 0..n-1, never below one bit.
   function automatic int lk_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lk_addr_map.sv
module lk_addr_map #(
   parameter int LANES   = 4,
   parameter int LANE_ID = 0,
   parameter int STW     = 8,
   parameter int AW      = 10
) (
   input  logic [STW-1:0] step,
   output logic [AW-1:0]  addr
);
   // Item index = step * LANES + LANE_ID; the cheapest form is picked here.
   generate
      if (LANES == 1) begin : g_single
         assign addr = AW'(step);
      end else if ((LANES & (LANES - 1)) == 0) begin : g_pow2
         localparam int LB = $clog2(LANES);
         localparam logic [LB-1:0] LID = LB'(LANE_ID);
         assign addr = AW'({step, LID});
      end else begin : g_mult
         assign addr = AW'(step) * AW'(LANES) + AW'(LANE_ID);
      end
   endgenerate
endmodule

// File: rtl/lk_walker.sv
module lk_walker #(
   parameter int STEPS = 250,
   parameter int STW   = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           last_wr,
   output logic           issue,
   output logic [STW-1:0] step,
   output logic           done
);
   localparam logic [STW-1:0] LAST_STEP = STW'(STEPS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue <= 1'b0;
         step  <= '0;
         done  <= 1'b0;
      end else if (start) begin
         issue <= 1'b1;
         step  <= '0;
         done  <= 1'b0;
      end else begin
         if (issue) begin
            if (step == LAST_STEP) issue <= 1'b0;
            else                   step  <= step + 1'b1;
         end
         if (last_wr) done <= 1'b1;
      end
   end
endmodule

// File: rtl/lk_lane.sv
module lk_lane #(
   parameter int W       = 8,
   parameter int LANES   = 4,
   parameter int LANE_ID = 0,
   parameter int AW      = 10,
   parameter int STW     = 8,
   parameter int YW      = 19
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue,
   input  logic [STW-1:0] step,
   input  logic [W-1:0]   k_in,
   input  logic [W-1:0]   a_in,
   input  logic [W-1:0]   b_in,
   input  logic [W-1:0]   c_in,
   output logic [AW-1:0]  rd_addr,
   output logic           wr_en,
   output logic [AW-1:0]  wr_addr,
   output logic [YW-1:0]  wr_data,
   output logic [STW-1:0] wr_step
);
   localparam int SW    = W + 1;
   localparam int PW    = 2 * SW;
   localparam int DEPTH = 4;   // memory read + sums + product + add K

   logic [DEPTH-1:0] vld;
   logic [STW-1:0]   tag [DEPTH];
   logic [SW-1:0]    sum_ab, sum_cc;
   logic [PW-1:0]    prod;
   logic [YW-1:0]    res;

   lk_addr_map #(.LANES(LANES), .LANE_ID(LANE_ID), .STW(STW), .AW(AW))
      u_rd_map (.step(step), .addr(rd_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else        vld <= {vld[DEPTH-2:0], issue};
   end

   always_ff @(posedge clk) begin
      tag[0] <= step;
      for (int i = 1; i < DEPTH; i++) tag[i] <= tag[i-1];
   end

   // Both sums share one stage; each operation is followed by a register.
   always_ff @(posedge clk) begin
      sum_ab <= SW'(a_in) + SW'(b_in);
      sum_cc <= SW'(c_in) + SW'(c_in);
      prod   <= PW'(sum_ab) * PW'(sum_cc);
      res    <= YW'(k_in) + YW'(prod);
   end

   lk_addr_map #(.LANES(LANES), .LANE_ID(LANE_ID), .STW(STW), .AW(AW))
      u_wr_map (.step(tag[DEPTH-1]), .addr(wr_addr));

   assign wr_en   = vld[DEPTH-1];
   assign wr_data = res;
   assign wr_step = tag[DEPTH-1];
endmodule

// File: rtl/lane_array_kernel.sv
module lane_array_kernel import lk_pkg::*; #(
   parameter  int W     = 8,
   parameter  int LANES = 4,
   parameter  int ITEMS = 1000,
   localparam int AW    = lk_width(ITEMS),
   localparam int YW    = 2 * (W + 1) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [W-1:0]        k_in,
   output logic                rd_en,
   output logic [LANES*AW-1:0] rd_addr,
   input  logic [LANES*W-1:0]  a_rd,
   input  logic [LANES*W-1:0]  b_rd,
   input  logic [LANES*W-1:0]  c_rd,
   output logic [LANES-1:0]    wr_en,
   output logic [LANES*AW-1:0] wr_addr,
   output logic [LANES*YW-1:0] wr_data,
   output logic                done
);
   localparam int STEPS = ITEMS / LANES;
   localparam int STW   = lk_width(STEPS);

   generate
      if (LANES < 1 || W < 1 || (ITEMS % LANES) != 0) begin : g_bad_cfg
         $error("lane_array_kernel: ITEMS must be a positive multiple of LANES");
      end
   endgenerate

   logic           issue;
   logic [STW-1:0] step;
   logic [STW-1:0] lane0_step;
   logic           last_wr;

   assign last_wr = wr_en[0] && (lane0_step == STW'(STEPS - 1));

   lk_walker #(.STEPS(STEPS), .STW(STW)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .last_wr(last_wr),
      .issue(issue), .step(step), .done(done)
   );

   assign rd_en = issue;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [STW-1:0] tag_out;
         lk_lane #(.W(W), .LANES(LANES), .LANE_ID(l), .AW(AW), .STW(STW), .YW(YW)) u_lane (
            .clk(clk), .rst_n(rst_n), .issue(issue), .step(step), .k_in(k_in),
            .a_in(a_rd[l*W +: W]), .b_in(b_rd[l*W +: W]), .c_in(c_rd[l*W +: W]),
            .rd_addr(rd_addr[l*AW +: AW]),
            .wr_en(wr_en[l]),
            .wr_addr(wr_addr[l*AW +: AW]),
            .wr_data(wr_data[l*YW +: YW]),
            .wr_step(tag_out)
         );
         if (l == 0) begin : g_tap
            assign lane0_step = tag_out;
         end
      end
   endgenerate
endmodule

// File: rtl/lk_checker.sv
module lk_checker #(
   parameter int W     = 8,
   parameter int LANES = 4,
   parameter int ITEMS = 1000,
   parameter int AW    = 10,
   parameter int YW    = 19
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_en,
   input logic [LANES*AW-1:0] wr_addr,
   input logic [LANES-1:0]    wr_en,
   input logic                done
);
   // R7: lanes write together
   assert_lanes_lockstep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en != '0) |-> (&wr_en));

   // R4: done rises the cycle after a write
   assert_done_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wr_en[0]));

   // R8: no read while done is high
   assert_no_read_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !done);

   // R8: every write was issued as a read four cycles earlier
   assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[0] |-> $past(rd_en, 4));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_chk
         // R2: lane l only writes its own residue class, inside the array
         assert_lane_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[l] |-> ((int'(wr_addr[l*AW +: AW]) % LANES) == l
                          && int'(wr_addr[l*AW +: AW]) < ITEMS));
      end
   endgenerate
endmodule

bind lane_array_kernel lk_checker #(
   .W(W), .LANES(LANES), .ITEMS(ITEMS), .AW(AW), .YW(YW)
) u_lk_checker (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_addr(wr_addr),
   .wr_en(wr_en), .done(done)
);

// File: tb/lane_array_kernel_tb_top.sv
module lane_array_kernel_tb_top;
   localparam int W     = 8;
   localparam int LANES = 4;
   localparam int ITEMS = 1000;
   localparam int AW    = 10;
   localparam int YW    = 19;
   localparam int M     = ITEMS / LANES;

   // Vector table: index, a, b, c (corners on every lane, first and last step)
   localparam int NV = 8;
   localparam int TBL [NV][4] = '{
      '{0, 0, 0, 0}, '{1, 255, 255, 255}, '{2, 255, 0, 0}, '{3, 0, 255, 1},
      '{500, 128, 128, 128}, '{997, 1, 2, 3}, '{998, 0, 0, 255}, '{999, 255, 255, 255}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] k_in = '0;
   logic rd_en, done;
   logic [LANES*AW-1:0] rd_addr, wr_addr;
   logic [LANES*W-1:0]  a_rd, b_rd, c_rd;
   logic [LANES-1:0]    wr_en;
   logic [LANES*YW-1:0] wr_data;

   int mem_a [ITEMS];
   int mem_b [ITEMS];
   int mem_c [ITEMS];
   longint y_mem [ITEMS];
   int wr_cnt [ITEMS];
   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   lane_array_kernel dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in),
      .rd_en(rd_en), .rd_addr(rd_addr), .a_rd(a_rd), .b_rd(b_rd), .c_rd(c_rd),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

   // Memory model: one-cycle read latency per lane port, write on strobe.
   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         int ra;
         int wa;
         ra = int'(rd_addr[l*AW +: AW]);
         if (ra < ITEMS) begin
            a_rd[l*W +: W] <= W'(mem_a[ra]);
            b_rd[l*W +: W] <= W'(mem_b[ra]);
            c_rd[l*W +: W] <= W'(mem_c[ra]);
         end
         wa = int'(wr_addr[l*AW +: AW]);
         if (wr_en[l] && wa < ITEMS) begin
            y_mem[wa]  <= longint'(wr_data[l*YW +: YW]);
            wr_cnt[wa] <= wr_cnt[wa] + 1;
         end
      end
   end

   function automatic longint expect_y(int a, int b, int c, int k);
      return longint'(k) + longint'(a + b) * longint'(2 * c);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int total_writes();
      int s = 0;
      for (int i = 0; i < ITEMS; i++) s += wr_cnt[i];
      return s;
   endfunction

   // Pulse start, then trace the ports cycle by cycle (R2, R4, R6, R7).
   task automatic run_trace(input int k);
      k_in  = W'(k);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < M + 7; cyc++) begin
         chk(rd_en == (cyc < M), "R4", "rd_en window", rd_en, cyc < M);
         chk(done == (cyc >= M + 4), "R4", "done timing", done, cyc >= M + 4);
         if (cyc == 0) chk(done == 1'b0, "R6", "done cleared by start", done, 0);
         chk((wr_en == '1) == (cyc >= 4 && cyc < M + 4) && (wr_en == '0 || wr_en == '1),
             "R7", "lockstep write window", wr_en, (cyc >= 4 && cyc < M + 4) ? 15 : 0);
         for (int l = 0; l < LANES; l++) begin
            if (cyc < M)
               chk(int'(rd_addr[l*AW +: AW]) == cyc * LANES + l, "R2", "read address",
                   rd_addr[l*AW +: AW], cyc * LANES + l);
            if (cyc >= 4 && cyc < M + 4)
               chk(int'(wr_addr[l*AW +: AW]) == (cyc - 4) * LANES + l, "R2", "write address",
                   wr_addr[l*AW +: AW], (cyc - 4) * LANES + l);
         end
         @(negedge clk);
      end
   endtask

   task automatic check_results(input int k, input int runs);
      int bad_val = 0;
      int bad_cnt = 0;
      int first = -1;
      for (int i = 0; i < ITEMS; i++) begin
         if (y_mem[i] != expect_y(mem_a[i], mem_b[i], mem_c[i], k)) begin
            bad_val++;
            if (first < 0) first = i;
         end
         if (wr_cnt[i] != runs) bad_cnt++;
      end
      chk(bad_val == 0, "R1", "mismatching results", bad_val, 0);
      chk(bad_cnt == 0, "R3", "indices not written once per pass", bad_cnt, 0);
      for (int v = 0; v < NV; v++) begin
         int ix = TBL[v][0];
         chk(y_mem[ix] == expect_y(TBL[v][1], TBL[v][2], TBL[v][3], k), "R1",
             $sformatf("table vector at index %0d", ix), y_mem[ix],
             expect_y(TBL[v][1], TBL[v][2], TBL[v][3], k));
      end
   endtask

   initial begin
      for (int i = 0; i < ITEMS; i++) begin
         mem_a[i] = (i * 37 + 11) % 256;
         mem_b[i] = (i * 91 + 5) % 256;
         mem_c[i] = (i * 13 + 200) % 256;
      end
      for (int v = 0; v < NV; v++) begin
         mem_a[TBL[v][0]] = TBL[v][1];
         mem_b[TBL[v][0]] = TBL[v][2];
         mem_c[TBL[v][0]] = TBL[v][3];
      end

      repeat (3) @(negedge clk);
      chk(done == 1'b0 && rd_en == 1'b0 && wr_en == '0, "R5", "outputs in reset",
          {done, rd_en, wr_en}, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(done == 1'b0 && rd_en == 1'b0 && wr_en == '0, "R5", "idle without start",
          {done, rd_en, wr_en}, 0);
      chk(total_writes() == 0, "R5", "writes without start", total_writes(), 0);

      run_trace(200);
      check_results(200, 1);

      repeat (20) @(negedge clk);
      chk(done == 1'b1, "R6", "done held until next start", done, 1);
      chk(wr_en == '0 && rd_en == 1'b0, "R8", "quiet while done", {rd_en, wr_en}, 0);

      run_trace(255);
      check_results(255, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule